// File: doc/BRIEF.md
# UART Transmit Readback Consistency Checker

This block sits beside a UART/LIN-style transmitter. It compares each transmitted bit with the level sampled on the receive pin. A separate baud unit supplies a mid-bit sample strobe, and the transmitter reports which part of the frame is on the line: idle, start, data, first stop, second stop or break field. A mismatch is not reported straight away. It is held in a sticky internal bit, and at the end of the frame it sets an error flag and raises a one-cycle status pulse.

Break frames have their own detection rules. In the edge rule, any rising edge on the input during the break is an error. In the level rule, any sampled high is an error. In the early-completion rule, the break is compared against the driven low, and a receiver completion that arrives during the break is also an error.

While the flag is set, the block gates the transmitter's start requests. Pending data and break triggers are dropped, and nothing new is accepted until software clears the flag and writes again. Receive-complete and receive-status events pass through, gated only by the receiver enable.

Top module: `uart_echo_chk`

## Requirements
- R1: With chk_en_i low, err_flag_o is forced to 0, no check is made, and no consistency status pulse is produced.
- R2: At each smp_i strobe during the start bit (tx_phase_i=1) or a data bit (tx_phase_i=2), a difference between rx_i and tx_bit_i marks the frame as erroneous.
- R3: During the second stop bit (tx_phase_i=4), rx_i is never compared.
- R4: A sampled rx_i of 0 during the first stop bit (tx_phase_i=3) marks the frame as erroneous.
- R5: During a break field (tx_phase_i=5) with brk_early_i=0 and brk_lvl_i=0, a sample of 1 that follows a sample of 0 in the same break is an error. The first break sample is compared against an assumed previous level of 1, so a steady high is not an error.
- R6: During a break field with brk_early_i=0 and brk_lvl_i=1, any sample of 1 is an error.
- R7: During a break field with brk_early_i=1, any sample of 1 is an error, and an rx_done_i pulse while the break is on the line is also an error.
- R8: err_flag_o stays low in the middle of a frame. It rises one cycle after the frame_end_i cycle of an erroneous frame. At the same time, stat_int_o pulses high for exactly one cycle.
- R9: While err_flag_o is set, tx_wr_i and brk_trig_i are discarded. Any data or break request still pending when the error is flagged is cancelled, so go_dat_o and go_brk_o stay low.
- R10: After flag_clr_i, a new tx_wr_i or brk_trig_i gives one go_dat_o or go_brk_o pulse while the transmitter is idle (tx_phase_i=0) and not ending a frame. A pending break takes priority over pending data.
- R11: With rx_en_i low, the check still runs, but rx_int_o stays low and rx_err_i does not reach stat_int_o.
- R12: Samples and rx_done_i pulses while tx_phase_i=0 are never checked.
- R13: rx_store_o follows rx_done_i whatever the error flag or the receiver enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chk_en_i | input | 1 | Consistency check enable |
| rx_en_i | input | 1 | Receiver enable |
| brk_early_i | input | 1 | Break rule: early completion and compare with low |
| brk_lvl_i | input | 1 | Break rule: level (1) or rising edge (0) when brk_early_i=0 |
| tx_phase_i | input | 3 | Frame part on the line: 0 idle, 1 start, 2 data, 3 stop1, 4 stop2, 5 break |
| tx_bit_i | input | 1 | Level being transmitted |
| rx_i | input | 1 | Receive pin level |
| smp_i | input | 1 | Mid-bit sample strobe |
| frame_end_i | input | 1 | One-cycle end-of-frame event from the transmitter |
| rx_done_i | input | 1 | Receiver completion event |
| rx_err_i | input | 1 | Receiver error status event |
| flag_clr_i | input | 1 | Software clear of the error flag |
| tx_wr_i | input | 1 | Transmit data write strobe |
| brk_trig_i | input | 1 | Break transmit trigger |
| err_flag_o | output | 1 | Consistency error flag |
| stat_int_o | output | 1 | Status interrupt pulse |
| rx_int_o | output | 1 | Receive-complete interrupt |
| rx_store_o | output | 1 | Store received data |
| go_dat_o | output | 1 | Start a data frame |
| go_brk_o | output | 1 | Start a break frame |

## Verification
Data frames use random bytes. Each frame carries at most one flipped readback bit, placed at random on the start, a data bit, the first stop or the second stop bit. This separates the compared window from the ignored second stop bit.

Break frames use sparse random receive patterns under each of the three break rules. A break that starts high but never rises tells the edge rule apart from the level rule. A receiver completion during the break separates the early-completion rule from the other two.

Directed sequences cover three more cases: a data write made during a failing frame, which must be dropped; writes made while the flag is held, which must be discarded; and a restart after the flag is cleared.

// File: rtl/uec_pkg.sv
package uec_pkg;
  localparam int PH_W = 3;
  typedef enum logic [PH_W-1:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_STOP1 = 3'd3,
    PH_STOP2 = 3'd4,
    PH_BREAK = 3'd5
  } tx_phase_e;
endpackage

// File: rtl/uec_bit_cmp.sv
module uec_bit_cmp
  import uec_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      chk_en_i,
  input  tx_phase_e phase_i,
  input  logic      tx_bit_i,
  input  logic      rx_i,
  input  logic      smp_i,
  input  logic      rx_done_i,
  input  logic      brk_early_i,
  input  logic      brk_lvl_i,
  output logic      hit_o
);
  logic prev_q;

  // previous break sample, preset high outside the break field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 prev_q <= 1'b1;
    else if (phase_i != PH_BREAK) prev_q <= 1'b1;
    else if (smp_i)              prev_q <= rx_i;
  end

  logic smp_hit;
  always_comb begin
    smp_hit = 1'b0;
    unique case (phase_i)
      PH_START, PH_DATA: smp_hit = (rx_i != tx_bit_i);
      PH_STOP1:          smp_hit = !rx_i;
      PH_BREAK: begin
        if (brk_early_i || brk_lvl_i) smp_hit = rx_i;
        else                          smp_hit = !prev_q && rx_i;
      end
      default:           smp_hit = 1'b0;
    endcase
  end

  logic early_hit;
  assign early_hit = brk_early_i && (phase_i == PH_BREAK) && rx_done_i;
  assign hit_o     = chk_en_i && ((smp_i && smp_hit) || early_hit);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_IDLE) |-> !hit_o);
  assert_stop2_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_STOP2) |-> !hit_o);
endmodule

// File: rtl/uec_err_flag.sv
module uec_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_en_i,
  input  logic hit_i,
  input  logic frame_end_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o,
  output logic set_o
);
  logic sticky_q, flag_q, pulse_q;

  assign set_o = chk_en_i && frame_end_i && (sticky_q || hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= 1'b0;
      flag_q   <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= set_o;
      if (!chk_en_i || frame_end_i) sticky_q <= 1'b0;
      else if (hit_i)               sticky_q <= 1'b1;
      // set wins over a clear in the same cycle
      if (!chk_en_i)  flag_q <= 1'b0;
      else if (set_o) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;

  assert_flag_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(frame_end_i));
  assert_pulse_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  assert_pulse_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> flag_q);
  assert_off_clean_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_en_i |=> (!flag_q && !pulse_q));
endmodule

// File: rtl/uec_tx_gate.sv
module uec_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic brk_trig_i,
  input  logic flag_i,
  input  logic set_i,
  input  logic idle_i,
  input  logic frame_end_i,
  output logic go_dat_o,
  output logic go_brk_o
);
  logic pend_dat_q, pend_brk_q, launch_q, ok, accept;

  assign accept   = !flag_i && !set_i;
  assign ok       = idle_i && !flag_i && !frame_end_i && !launch_q;
  assign go_brk_o = ok && pend_brk_q;
  assign go_dat_o = ok && pend_dat_q && !pend_brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_dat_q <= 1'b0;
      pend_brk_q <= 1'b0;
      launch_q   <= 1'b0;
    end else begin
      launch_q <= go_dat_o || go_brk_o;
      if (set_i)                  pend_dat_q <= 1'b0;
      else if (wr_i && accept)    pend_dat_q <= 1'b1;
      else if (go_dat_o)          pend_dat_q <= 1'b0;
      if (set_i)                  pend_brk_q <= 1'b0;
      else if (brk_trig_i && accept) pend_brk_q <= 1'b1;
      else if (go_brk_o)          pend_brk_q <= 1'b0;
    end
  end

  assert_pend_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> (!pend_dat_q && !pend_brk_q));
  assert_one_go_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({go_dat_o, go_brk_o}));
  assert_go_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_dat_o || go_brk_o) |=> !(go_dat_o || go_brk_o));
endmodule

// File: rtl/uart_echo_chk.sv
module uart_echo_chk
  import uec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            chk_en_i,
  input  logic            rx_en_i,
  input  logic            brk_early_i,
  input  logic            brk_lvl_i,
  input  logic [PH_W-1:0] tx_phase_i,
  input  logic            tx_bit_i,
  input  logic            rx_i,
  input  logic            smp_i,
  input  logic            frame_end_i,
  input  logic            rx_done_i,
  input  logic            rx_err_i,
  input  logic            flag_clr_i,
  input  logic            tx_wr_i,
  input  logic            brk_trig_i,
  output logic            err_flag_o,
  output logic            stat_int_o,
  output logic            rx_int_o,
  output logic            rx_store_o,
  output logic            go_dat_o,
  output logic            go_brk_o
);
  tx_phase_e phase;
  logic hit, dce_pulse, dce_set;

  assign phase = tx_phase_e'(tx_phase_i);

  uec_bit_cmp u_cmp (
    .clk_i, .rst_ni, .chk_en_i,
    .phase_i     (phase),
    .tx_bit_i, .rx_i, .smp_i, .rx_done_i, .brk_early_i, .brk_lvl_i,
    .hit_o       (hit)
  );

  uec_err_flag u_flag (
    .clk_i, .rst_ni, .chk_en_i,
    .hit_i       (hit),
    .frame_end_i,
    .clr_i       (flag_clr_i),
    .flag_o      (err_flag_o),
    .pulse_o     (dce_pulse),
    .set_o       (dce_set)
  );

  uec_tx_gate u_gate (
    .clk_i, .rst_ni,
    .wr_i        (tx_wr_i),
    .brk_trig_i,
    .flag_i      (err_flag_o),
    .set_i       (dce_set),
    .idle_i      (phase == PH_IDLE),
    .frame_end_i,
    .go_dat_o, .go_brk_o
  );

  // receive events: storage never blocked, interrupts gated by receiver enable
  assign rx_store_o = rx_done_i;
  assign rx_int_o   = rx_done_i && rx_en_i;
  assign stat_int_o = dce_pulse || (rx_err_i && rx_en_i);

  assert_rx_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !dce_pulse) |-> (!rx_int_o && !stat_int_o));
  assert_store_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |-> rx_store_o);
endmodule

// File: tb/tb_uart_echo_chk.sv
`timescale 1ns/1ps
module tb_uart_echo_chk;
  import uec_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chk_en = 1'b1, rx_en = 1'b1, brk_early = 1'b0, brk_lvl = 1'b0;
  logic [2:0] phase = 3'd0;
  logic txb = 1'b1, rxl = 1'b1, smp = 1'b0, fend = 1'b0, rxd = 1'b0, rxe = 1'b0;
  logic fclr = 1'b0, twr = 1'b0, btrig = 1'b0;
  logic flag, stat, rint, rstore, gdat, gbrk;

  int n_chk = 0, n_fail = 0, n_gdat = 0, n_gbrk = 0;

  always #10 clk = ~clk;

  uart_echo_chk dut (
    .clk_i(clk), .rst_ni(rst_n), .chk_en_i(chk_en), .rx_en_i(rx_en),
    .brk_early_i(brk_early), .brk_lvl_i(brk_lvl), .tx_phase_i(phase),
    .tx_bit_i(txb), .rx_i(rxl), .smp_i(smp), .frame_end_i(fend),
    .rx_done_i(rxd), .rx_err_i(rxe), .flag_clr_i(fclr), .tx_wr_i(twr),
    .brk_trig_i(btrig), .err_flag_o(flag), .stat_int_o(stat),
    .rx_int_o(rint), .rx_store_o(rstore), .go_dat_o(gdat), .go_brk_o(gbrk)
  );

  always @(posedge clk) begin
    if (gdat) n_gdat++;
    if (gbrk) n_gbrk++;
  end

  task automatic chk(input string tag, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  task automatic chk_n(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive_bit(input logic [2:0] ph, input logic tb_, input logic rb,
                           input logic done_now, input logic wr_now);
    for (int c = 0; c < 4; c++) begin
      phase = ph; txb = tb_; rxl = rb;
      smp = (c == 1);
      rxd = done_now && (c == 2);
      twr = wr_now && (c == 0);
      @(negedge clk);
    end
    smp = 1'b0; rxd = 1'b0; twr = 1'b0;
  endtask

  // ends the frame and checks flag and status pulse (R8)
  task automatic end_frame(input logic expv, input string tag);
    chk({tag, " R8 no flag mid-frame"}, flag, 1'b0);
    phase = PH_IDLE; txb = 1'b1; rxl = 1'b1; fend = 1'b1;
    @(negedge clk);
    fend = 1'b0;
    chk({tag, " flag"}, flag, expv);
    chk({tag, " R8 status pulse"}, stat, expv);
    @(negedge clk);
    if (expv) chk({tag, " R8 pulse single"}, stat, 1'b0);
  endtask

  task automatic clear_flag();
    fclr = 1'b1; @(negedge clk); fclr = 1'b0; @(negedge clk);
  endtask

  function automatic logic exp_data(input logic [10:0] flip);
    return chk_en && (|flip[9:0]);
  endfunction

  task automatic send_data(input logic [7:0] d, input logic [10:0] flip,
                           input logic two, input logic wr_first, input string tag);
    logic [10:0] b;
    b = {1'b1, 1'b1, d, 1'b0};
    drive_bit(PH_START, b[0], b[0] ^ flip[0], 1'b0, wr_first);
    for (int i = 1; i <= 8; i++) drive_bit(PH_DATA, b[i], b[i] ^ flip[i], 1'b0, 1'b0);
    drive_bit(PH_STOP1, 1'b1, 1'b1 ^ flip[9], 1'b0, 1'b0);
    if (two) drive_bit(PH_STOP2, 1'b1, 1'b1 ^ flip[10], 1'b0, 1'b0);
    end_frame(exp_data(two ? flip : {1'b0, flip[9:0]}), tag);
  endtask

  function automatic logic exp_brk(input int len, input logic [15:0] pat,
                                   input int done_idx, input logic stop_rx);
    logic e, prev;
    e = 1'b0; prev = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (brk_early || brk_lvl) begin
        if (pat[i]) e = 1'b1;
      end else if (!prev && pat[i]) e = 1'b1;
      prev = pat[i];
    end
    if (brk_early && done_idx >= 0) e = 1'b1;
    if (!stop_rx) e = 1'b1;
    return e && chk_en;
  endfunction

  task automatic send_break(input int len, input logic [15:0] pat, input int done_idx,
                            input logic stop_rx, input string tag);
    for (int i = 0; i < len; i++) drive_bit(PH_BREAK, 1'b0, pat[i], i == done_idx, 1'b0);
    drive_bit(PH_STOP1, 1'b1, stop_rx, 1'b0, 1'b0);
    end_frame(exp_brk(len, pat, done_idx, stop_rx), tag);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g0, b0;
    logic [10:0] fl;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset flag", flag, 1'b0);
    chk("reset stat", stat, 1'b0);
    chk("reset go", gdat | gbrk, 1'b0);

    // R2 clean and mismatching data frames
    send_data(8'hA5, 11'h0, 1'b0, 1'b0, "R2 clean");
    send_data(8'h3C, 11'h004, 1'b0, 1'b0, "R2 data mismatch");
    clear_flag();
    chk("R10 flag cleared", flag, 1'b0);
    send_data(8'h00, 11'h001, 1'b1, 1'b0, "R2 start mismatch");
    clear_flag();
    // R3 second stop ignored, R4 first stop low
    send_data(8'hFF, 11'h400, 1'b1, 1'b0, "R3 stop2 flip ignored");
    send_data(8'h55, 11'h200, 1'b1, 1'b0, "R4 stop1 low");
    clear_flag();

    // R1 check disabled
    chk_en = 1'b0;
    send_data(8'h12, 11'h0F0, 1'b0, 1'b0, "R1 disabled");
    chk_en = 1'b1;

    // R12 idle reception not checked
    brk_early = 1'b1;
    for (int i = 0; i < 6; i++) begin
      rxl = i[0]; smp = 1'b1; rxd = 1'b1; @(negedge clk);
    end
    smp = 1'b0; rxd = 1'b0; rxl = 1'b1;
    brk_early = 1'b0;
    send_data(8'h81, 11'h0, 1'b0, 1'b0, "R12 idle rx unchecked");

    // R5 / R6: break that starts high but never rises
    brk_lvl = 1'b0;
    send_break(11, 16'h0001, -1, 1'b1, "R5 edge steady high");
    send_break(11, 16'h0010, -1, 1'b1, "R5 edge rise");
    clear_flag();
    brk_lvl = 1'b1;
    send_break(11, 16'h0001, -1, 1'b1, "R6 level high");
    clear_flag();
    send_break(11, 16'h0000, -1, 1'b1, "R6 level clean");
    // R7 early completion
    brk_lvl = 1'b0; brk_early = 1'b1;
    send_break(11, 16'h0000, -1, 1'b1, "R7 early clean");
    send_break(11, 16'h0000, 9, 1'b1, "R7 early rx done");
    clear_flag();
    brk_early = 1'b0;

    // R9 pending write during failing frame is dropped
    g0 = n_gdat;
    send_data(8'h77, 11'h008, 1'b0, 1'b1, "R9 pending write frame");
    repeat (4) @(negedge clk);
    chk_n("R9 pending write dropped", n_gdat, g0);
    // R9 writes and triggers while flagged
    g0 = n_gdat; b0 = n_gbrk;
    twr = 1'b1; btrig = 1'b1; @(negedge clk); twr = 1'b0; btrig = 1'b0;
    repeat (4) @(negedge clk);
    chk_n("R9 write while flagged", n_gdat, g0);
    chk_n("R9 trigger while flagged", n_gbrk, b0);
    // R13 storage with flag set
    rxd = 1'b1; #1;
    chk("R13 store with flag", rstore, 1'b1);
    @(negedge clk); rxd = 1'b0;
    // R10 resume
    clear_flag();
    chk_n("R10 nothing left pending", n_gdat + n_gbrk, g0 + b0);
    twr = 1'b1; @(negedge clk); twr = 1'b0;
    repeat (3) @(negedge clk);
    chk_n("R10 data resumes", n_gdat, g0 + 1);
    btrig = 1'b1; twr = 1'b1; @(negedge clk); btrig = 1'b0; twr = 1'b0;
    repeat (4) @(negedge clk);
    chk_n("R10 break first", n_gbrk, b0 + 1);
    chk_n("R10 data after break", n_gdat, g0 + 2);
    // R10 clean frame with pending write launches after frame end
    g0 = n_gdat;
    send_data(8'h42, 11'h0, 1'b0, 1'b1, "R10 pending clean frame");
    repeat (2) @(negedge clk);
    chk_n("R10 pending write launches", n_gdat, g0 + 1);

    // R11 receiver disabled
    rx_en = 1'b0;
    rxd = 1'b1; rxe = 1'b1; #1;
    chk("R11 no rx int", rint, 1'b0);
    chk("R11 no rx status", stat, 1'b0);
    chk("R13 store when disabled", rstore, 1'b1);
    @(negedge clk); rxd = 1'b0; rxe = 1'b0;
    send_data(8'h99, 11'h010, 1'b0, 1'b0, "R11 check while rx off");
    clear_flag();
    rx_en = 1'b1;
    rxd = 1'b1; rxe = 1'b1; #1;
    chk("R11 rx int enabled", rint, 1'b1);
    chk("R11 rx status enabled", stat, 1'b1);
    @(negedge clk); rxd = 1'b0; rxe = 1'b0;

    // random mix
    for (int k = 0; k < 40; k++) begin
      rx_en = 1'($urandom);
      if ($urandom_range(0, 2) == 0) begin
        logic [15:0] p;
        int ln, di;
        brk_early = 1'($urandom);
        brk_lvl   = 1'($urandom);
        ln = $urandom_range(10, 13);
        p  = 16'($urandom & $urandom & $urandom);
        di = ($urandom_range(0, 3) == 0) ? $urandom_range(0, ln - 1) : -1;
        send_break(ln, p, di, ($urandom_range(0, 5) != 0), "R5 R6 R7 random break");
      end else begin
        fl = ($urandom_range(0, 2) == 0) ? 11'(1 << $urandom_range(0, 10)) : 11'h0;
        send_data(8'($urandom), fl, 1'($urandom), 1'b0, "R2 R3 R4 random data");
      end
      if (flag) clear_flag();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule